// File: doc/BRIEF.md
# Burst Column Address Generator

This block supplies the column address for each beat of a synchronous DRAM read or write burst. A one-cycle start strobe captures a starting column, a burst length code, an ordering select and the read/write context. From the next cycle on, the block gives one column address per clock with a valid flag. A last-beat flag marks the final beat of a burst that has a fixed length.

Two beat orderings are offered. The sequential order counts upward and wraps inside the aligned block that the burst length selects. The interleaved order XORs a beat counter into the low start bits. A full-page burst walks all columns of the row in sequence and never ends by itself. A stop strobe cuts any burst short. A start strobe that arrives during a burst begins the new burst at once. When the single-beat write mode is set, every write lasts one beat whatever the programmed length, and reads keep the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, valid_o and last_o are 0.
- R2: The cycle after start_i is sampled high, valid_o is 1 and col_o equals the sampled start_col_i.
- R3: With seq_or_ilv_i = 0 and len_code_i of 0, 1, 2 or 3 (1, 2, 4 or 8 beats), beat k has low bits (start + k) mod the burst length.
- R4: With seq_or_ilv_i = 1 and a fixed length, beat k has low bits equal to the start low bits XOR k (start 5, 8 beats gives 5,4,7,6,1,0,3,2).
- R5: During a fixed-length burst, the column bits above the low three bits keep the start value on every beat.
- R6: len_code_i = 7 selects a full-page burst. Its address is (start + k) mod 512 whatever seq_or_ilv_i is, it continues past column 511 to 0, and last_o stays 0.
- R7: last_o is 1 only on the final beat of a fixed-length burst, and valid_o is 0 in the next cycle unless a start arrives.
- R8: A stop_i sampled high with no start ends the burst, so valid_o is 0 in the next cycle, at any length including full page.
- R9: When write_i and one_wr_mode_i are both 1 at start, the burst is one beat with last_o set. A read, or a write with the mode off, uses the programmed length.
- R10: A start during an active burst abandons it, and the next cycle shows the new start column as beat 0 of the new burst.
- R11: Reserved length codes 4, 5 and 6 give a one-beat burst.
- R12: When start_i and stop_i are high in the same cycle, the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst from the fields below |
| stop_i | input | 1 | Truncate the active burst |
| start_col_i | input | 9 | Starting column |
| len_code_i | input | 3 | Burst length code: 0..3 give 1,2,4,8 beats, 7 gives full page |
| seq_or_ilv_i | input | 1 | 0 gives sequential order, 1 gives interleaved order |
| write_i | input | 1 | The burst is a write |
| one_wr_mode_i | input | 1 | Single-beat write mode |
| col_o | output | 9 | Column for the current beat |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Start columns with nonzero low bits go through both orderings at 2, 4 and 8 beats. This separates a wrap inside the aligned block from a carry into the upper bits, and separates the XOR pattern from a plain rotation. A full-page burst that starts near column 511 tests the wrap across the whole row and checks that no last flag appears, with interleave both on and off. Truncation, restart in mid-burst, a start and stop in the same cycle, the single-beat write mode against reads, and the reserved length codes each test how a burst ends early or is cut to one beat.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             seq_or_ilv_i,
  input  logic             write_i,
  input  logic             one_wr_mode_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int HI_LSB = 3;

  logic             act, ilv, page;
  logic [COL_W-1:0] base, beat, span;
  logic [COL_W-1:0] span_nx;
  logic             one_beat, page_nx;

  assign one_beat = write_i && one_wr_mode_i;
  assign page_nx  = (len_code_i == 3'd7) && !one_beat;

  always_comb begin
    case (len_code_i)
      3'd1:    span_nx = COL_W'(1);
      3'd2:    span_nx = COL_W'(3);
      3'd3:    span_nx = COL_W'(7);
      3'd7:    span_nx = '1;
      default: span_nx = '0;
    endcase
    if (one_beat) span_nx = '0;
  end

  logic [COL_W-1:0] low_bits;
  assign low_bits = ilv ? (base ^ beat) : (base + beat);
  assign col_o    = (base & ~span) | (low_bits & span);
  assign valid_o  = act;
  assign last_o   = act && !page && (beat == span);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      ilv  <= 1'b0;
      page <= 1'b0;
      base <= '0;
      beat <= '0;
      span <= '0;
    end else if (start_i) begin
      act  <= 1'b1;
      base <= start_col_i;
      beat <= '0;
      span <= span_nx;
      page <= page_nx;
      ilv  <= seq_or_ilv_i && !page_nx;
    end else if (stop_i) begin
      act <= 1'b0;
    end else if (act) begin
      if (last_o) act <= 1'b0;
      beat <= beat + 1'b1;
    end
  end

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !page && $past(valid_o) && !$past(start_i))
      |-> (col_o[COL_W-1:HI_LSB] == $past(col_o[COL_W-1:HI_LSB])));

  a_r7_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  a_r7_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o);

  a_r9_one_beat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && write_i && one_wr_mode_i) |=> last_o);

  a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_code_i == 3'd7 && !(write_i && one_wr_mode_i)) |=> !last_o);
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  logic       clk = 0, rst_n = 0;
  logic       start_i = 0, stop_i = 0;
  logic [8:0] start_col_i = 0;
  logic [2:0] len_code_i = 0;
  logic       seq_or_ilv_i = 0, write_i = 0, one_wr_mode_i = 0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  burst_col_gen dut (.*);

  always #2 clk = ~clk;

  task automatic check(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected beat", {last_o, col_o}, 0);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({last_o, col_o} == e, t, {last_o, col_o}, e);
      end
    end
  end

  task automatic launch(input logic [8:0] col, input logic [2:0] code, input bit ilv,
                        input bit wr, input bit sw, input int take, input string tag);
    int  blen;
    bit  fp;
    logic [8:0] m, a;
    blen = (code <= 3) ? (1 << code) : (code == 7 ? 512 : 1);
    fp   = (code == 7);
    if (wr && sw) begin blen = 1; fp = 0; end
    m = 9'(blen - 1);
    if (take > blen) take = blen;
    for (int i = 0; i < take; i++) begin
      if (fp) a = 9'(col + i);
      else a = (col & ~m) | ((ilv ? (col ^ 9'(i)) : 9'(col + i)) & m);
      exp_q.push_back({(!fp && i == blen - 1), a});
      tag_q.push_back(tag);
    end
    start_i = 1; start_col_i = col; len_code_i = code;
    seq_or_ilv_i = ilv; write_i = wr; one_wr_mode_i = sw;
    @(negedge clk);
    start_i = 0; stop_i = 0;
    repeat (take - 1) @(negedge clk);
  endtask

  task automatic expect_idle(input string tag);
    @(negedge clk);
    stop_i = 0;
    check(valid_o == 0, tag, valid_o, 0);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 0 && last_o == 0, "R1 in reset", {valid_o, last_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(valid_o == 0 && last_o == 0, "R1 after reset", {valid_o, last_o}, 0);

    launch(9'h041, 3'd2, 0, 0, 0, 99, "R3 R2 seq BL4");  expect_idle("R7 seq BL4 end");
    launch(9'h041, 3'd2, 1, 0, 0, 99, "R4 ilv BL4");     expect_idle("R7 ilv BL4 end");
    launch(9'h01D, 3'd3, 1, 0, 0, 99, "R4 ilv BL8");     expect_idle("R7 ilv BL8 end");
    launch(9'h1FD, 3'd3, 0, 0, 0, 99, "R3 R5 seq BL8");  expect_idle("R7 seq BL8 end");
    launch(9'h00F, 3'd1, 0, 0, 0, 99, "R3 seq BL2");     expect_idle("R7 BL2 end");
    launch(9'h123, 3'd0, 1, 0, 0, 99, "R3 BL1");         expect_idle("R7 BL1 end");

    launch(9'd505, 3'd7, 0, 0, 0, 12, "R6 page wrap");
    stop_i = 1; expect_idle("R8 page stop");
    launch(9'd3, 3'd7, 1, 0, 0, 6, "R6 page ignores ilv");
    stop_i = 1; expect_idle("R8 page ilv stop");
    launch(9'h0A2, 3'd3, 0, 0, 0, 3, "R8 BL8 before stop");
    stop_i = 1; expect_idle("R8 BL8 stopped");

    launch(9'h0A2, 3'd3, 0, 1, 1, 99, "R9 single write"); expect_idle("R9 single write end");
    launch(9'h0A2, 3'd3, 1, 0, 1, 99, "R9 read keeps length"); expect_idle("R9 read end");
    launch(9'h0A6, 3'd2, 0, 1, 0, 99, "R9 write mode off"); expect_idle("R9 write end");
    launch(9'h150, 3'd7, 0, 1, 1, 99, "R9 single write page code"); expect_idle("R9 page code end");

    launch(9'h033, 3'd3, 0, 0, 0, 2, "R10 first burst");
    launch(9'h18E, 3'd2, 1, 0, 0, 99, "R10 restarted");  expect_idle("R10 end");

    launch(9'h077, 3'd5, 0, 0, 0, 99, "R11 reserved 5");  expect_idle("R11 end");
    launch(9'h078, 3'd4, 1, 0, 0, 99, "R11 reserved 4");  expect_idle("R11 end 4");

    stop_i = 1;
    launch(9'h0C1, 3'd1, 0, 0, 0, 99, "R12 start beats stop"); expect_idle("R12 end");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end
endmodule